// File: doc/BRIEF.md
# Target Clock Line Controller

This block owns the three outgoing debug lines toward a target device: the test clock (TCK, also used as the target's functional clock TCLK), the mode select line (TMS) and the data input line (TDI). A controller issues one-cycle commands, each made of an opcode and a 32-bit argument. The block can set the clock to a requested level, emit a counted burst of full clock cycles, choose between a slow and a fast half-period for those bursts, and set the mode and data lines. The last level driven on each line is always visible on a readback byte. Tracking of the target's TAP state and any serial data shifting are handled elsewhere.

A burst is measured in full clock cycles, so a count of N produces 2N edges. The burst starts from whatever level the clock line already holds and returns to that level at the end. While a burst runs the block raises `busy` and ignores every command. The half-period lengths are parameters counted in system clock cycles, with the fast one shorter than the slow one.

Top module: `tgt_line_ctrl`

## Requirements
- R1: After reset the clock, mode and data lines are all low, `busy` is low, the readback byte is zero, and the slow half-period is in force.
- R2: Opcode 1 (set clock) drives the clock line low when the argument is zero and high when any argument bit is set; the new level appears in the cycle after the command is taken.
- R3: Opcode 4 (set lines) drives the mode line from argument bit 0 and the data line from argument bit 1, visible in the cycle after the command is taken.
- R4: The readback byte carries the clock line in bit 0, the mode line in bit 1 and the data line in bit 2, with bits 7 to 3 zero, and always matches the levels currently driven.
- R5: Opcode 3 (speed) selects the slow half-period when the argument is zero and the fast half-period when any argument bit is set; the choice applies to bursts started afterwards.
- R6: Opcode 2 (burst) with a nonzero count N toggles the clock line 2N times, one toggle every H system cycles where H is the selected half-period, the first toggle H cycles after the command is taken, and leaves the line at its starting level.
- R7: During a burst of count N, `busy` is high for exactly 2N*H consecutive cycles, starting the cycle after the command is taken and falling together with the last toggle.
- R8: A burst with a count of zero produces no clock edge and leaves `busy` low; outside a burst the clock line changes only on a set-clock command.
- R9: Any command presented while `busy` is high is ignored: it changes no line, does not alter the speed choice and does not lengthen or restart the running burst.
- R10: Opcodes 0, 5, 6 and 7 are ignored and change no line and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one command per cycle in which it is high |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 32 | Command argument (level, speed flag, line levels or burst count) |
| line_tck | output | 1 | Clock line toward the target |
| line_tms | output | 1 | Mode select line toward the target |
| line_tdi | output | 1 | Data input line toward the target |
| readback | output | 8 | Last driven line levels |
| busy | output | 1 | High while a burst is in progress |

## Verification
The collision that matters is a new command landing in the very cycle a burst finishes its last toggle. The bench provokes it by holding a set-clock command asserted across the end of a burst, so the final toggle edge and the command are presented at the same clock edge. It judges that the burst completes first, with the line back at its starting level and the command refused at that edge, and that the held command takes effect exactly one cycle later. A second sweep presents commands of every kind in the middle of a burst and confirms the burst length, the lines and the speed choice are untouched.

// File: rtl/tlc_pkg.sv
// Package: shared opcode encoding for the target clock line controller.
// Assumes a 3-bit opcode field; unlisted codes are treated as no-ops.
package tlc_pkg;

    typedef enum logic [2:0] {
        OP_SET_CLK = 3'd1,
        OP_BURST   = 3'd2,
        OP_SPEED   = 3'd3,
        OP_LINES   = 3'd4
    } tlc_op_e;

endpackage

// File: rtl/tlc_cmd_decode.sv
// Module: tlc_cmd_decode
// Turns a command strobe into one-hot accept pulses. Assumes the caller
// supplies the registered busy flag; a busy cycle accepts nothing.
module tlc_cmd_decode
    import tlc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       busy,
    output logic       take_clk,
    output logic       take_burst,
    output logic       take_speed,
    output logic       take_lines
);

    logic accept;

    // Purpose: gate the strobe with busy and split by opcode.
    always_comb begin
        accept     = cmd_valid && !busy;
        take_clk   = accept && (cmd_op == OP_SET_CLK);
        take_burst = accept && (cmd_op == OP_BURST);
        take_speed = accept && (cmd_op == OP_SPEED);
        take_lines = accept && (cmd_op == OP_LINES);
    end

endmodule

// File: rtl/tlc_burst_engine.sv
// Module: tlc_burst_engine
// Counts out a burst of full clock cycles as 2N half-periods and pulses
// flip once per half-period. Assumes start is only raised while idle and
// that 1 <= FAST_HALF < SLOW_HALF. The half-period is latched at start.
module tlc_burst_engine #(
    parameter int COUNT_W   = 32,
    parameter int SLOW_HALF = 8,
    parameter int FAST_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COUNT_W-1:0] count,
    input  logic               fast,
    output logic               flip,
    output logic               busy
);

    localparam int HALF_W = $clog2(SLOW_HALF + 1);
    localparam int EDGE_W = COUNT_W + 1;
    localparam logic [HALF_W-1:0] SLOW_M1 = HALF_W'(SLOW_HALF - 1);
    localparam logic [HALF_W-1:0] FAST_M1 = HALF_W'(FAST_HALF - 1);

    logic [EDGE_W-1:0] edges_left;
    logic [HALF_W-1:0] tick;
    logic [HALF_W-1:0] reload;

    // Purpose: load a burst, then step the half-period timer and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_left <= '0;
            tick       <= '0;
            reload     <= '0;
        end else if (start && (count != '0)) begin
            edges_left <= {count, 1'b0};
            tick       <= fast ? FAST_M1 : SLOW_M1;
            reload     <= fast ? FAST_M1 : SLOW_M1;
        end else if (edges_left != '0) begin
            if (tick == '0) begin
                edges_left <= edges_left - 1'b1;
                tick       <= reload;
            end else begin
                tick <= tick - 1'b1;
            end
        end
    end

    // Purpose: derive the toggle pulse and busy from the counters.
    always_comb begin
        busy = (edges_left != '0);
        flip = busy && (tick == '0);
    end

endmodule

// File: rtl/tlc_line_regs.sv
// Module: tlc_line_regs
// Holds the three driven line levels. Assumes set_clk and flip never
// coincide (the decoder refuses commands during a burst).
module tlc_line_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic set_clk,
    input  logic clk_lvl,
    input  logic set_lines,
    input  logic tms_lvl,
    input  logic tdi_lvl,
    input  logic flip,
    output logic tck_q,
    output logic tms_q,
    output logic tdi_q
);

    // Purpose: clock line follows set-clock commands and burst toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_q <= 1'b0;
        end else if (set_clk) begin
            tck_q <= clk_lvl;
        end else if (flip) begin
            tck_q <= ~tck_q;
        end
    end

    // Purpose: mode and data lines follow set-lines commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tms_q <= 1'b0;
            tdi_q <= 1'b0;
        end else if (set_lines) begin
            tms_q <= tms_lvl;
            tdi_q <= tdi_lvl;
        end
    end

endmodule

// File: rtl/tgt_line_ctrl.sv
// Module: tgt_line_ctrl (top)
// Drives clock, mode and data lines toward a debug target, runs counted
// clock bursts at a selectable speed and reports the last driven levels.
// Assumes 1 <= FAST_HALF < SLOW_HALF (half-periods in system cycles).
module tgt_line_ctrl #(
    parameter int COUNT_W   = 32,
    parameter int SLOW_HALF = 8,
    parameter int FAST_HALF = 2,
    parameter int RB_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [COUNT_W-1:0] cmd_arg,
    output logic               line_tck,
    output logic               line_tms,
    output logic               line_tdi,
    output logic [RB_W-1:0]    readback,
    output logic               busy
);

    localparam int LINE_N = 3;

    logic take_clk, take_burst, take_speed, take_lines;
    logic flip;
    logic fast_q;
    logic [LINE_N-1:0] lines;

    tlc_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .take_clk  (take_clk),
        .take_burst(take_burst),
        .take_speed(take_speed),
        .take_lines(take_lines)
    );

    // Purpose: remember the speed choice; slow after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (take_speed) begin
            fast_q <= |cmd_arg;
        end
    end

    tlc_burst_engine #(
        .COUNT_W  (COUNT_W),
        .SLOW_HALF(SLOW_HALF),
        .FAST_HALF(FAST_HALF)
    ) u_burst (
        .clk  (clk),
        .rst_n(rst_n),
        .start(take_burst),
        .count(cmd_arg),
        .fast (fast_q),
        .flip (flip),
        .busy (busy)
    );

    tlc_line_regs u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_clk  (take_clk),
        .clk_lvl  (|cmd_arg),
        .set_lines(take_lines),
        .tms_lvl  (cmd_arg[0]),
        .tdi_lvl  (cmd_arg[1]),
        .flip     (flip),
        .tck_q    (line_tck),
        .tms_q    (line_tms),
        .tdi_q    (line_tdi)
    );

    // Purpose: pack line levels into the readback byte, upper bits zero.
    always_comb begin
        lines    = {line_tdi, line_tms, line_tck};
        readback = '0;
        for (int i = 0; i < LINE_N; i++) begin
            readback[i] = lines[i];
        end
    end

endmodule

// File: rtl/tgt_line_ctrl_chk.sv
// Module: tgt_line_ctrl_chk
// Temporal checks on the line controller's ports, bound to the top.
module tgt_line_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic [31:0] cmd_arg,
    input logic        line_tck,
    input logic        line_tms,
    input logic        line_tdi,
    input logic        busy
);

    logic take_any;
    logic start_lvl;

    assign take_any = cmd_valid && !busy;

    // Purpose: remember the clock level at the moment a burst is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_lvl <= 1'b0;
        end else if (take_any && cmd_op == 3'd2) begin
            start_lvl <= line_tck;
        end
    end

    AST_SET_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (take_any && cmd_op == 3'd1) |=> (line_tck == $past(|cmd_arg))); // R2
    AST_SET_LINES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (take_any && cmd_op == 3'd4) |=> (line_tms == $past(cmd_arg[0]) && line_tdi == $past(cmd_arg[1]))); // R3
    AST_BURST_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (line_tck == start_lvl)); // R6
    AST_ZERO_BURST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_any && cmd_op == 3'd2 && cmd_arg == 32'd0) |=> !busy); // R8
    AST_IDLE_CLK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op == 3'd1)) |=> $stable(line_tck)); // R8
    AST_BUSY_FREEZES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(line_tms) && $stable(line_tdi))); // R9

endmodule

bind tgt_line_ctrl tgt_line_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_arg  (cmd_arg),
    .line_tck (line_tck),
    .line_tms (line_tms),
    .line_tdi (line_tdi),
    .busy     (busy)
);

// File: tb/tgt_line_ctrl_test.sv
`timescale 1ns/1ps
module tgt_line_ctrl_test;

    localparam int S = 5;
    localparam int F = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_arg = 32'd0;
    logic        line_tck, line_tms, line_tdi, busy;
    logic [7:0]  readback;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    tgt_line_ctrl #(.COUNT_W(32), .SLOW_HALF(S), .FAST_HALF(F)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .line_tck(line_tck), .line_tms(line_tms),
        .line_tdi(line_tdi), .readback(readback), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One-cycle command; returns at the negedge right after it is taken.
    task automatic send(input logic [2:0] op, input logic [31:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 32'd0;
    endtask

    // Watches a burst from the negedge after it is taken until busy drops.
    task automatic watch(input int h, output int busy_n, output int flips, output int off_grid);
        logic prev;
        int m;
        prev = line_tck; busy_n = 0; flips = 0; off_grid = 0; m = 1;
        while (m < 20000) begin
            if (line_tck !== prev) begin
                flips++;
                if ((m - 1) % h != 0) off_grid++;
                prev = line_tck;
            end
            if (!busy) break;
            busy_n++;
            @(negedge clk);
            m++;
        end
    endtask

    task automatic burst(input int n, input int h, input logic start, input string tag);
        int bn, fl, og;
        send(3'd2, 32'(n));
        watch(h, bn, fl, og);
        check(fl == 2 * n, {tag, " R6 toggles"}, fl, 2 * n);
        check(og == 0, {tag, " R6 toggle spacing"}, og, 0);
        check(line_tck == start, {tag, " R6 end level"}, line_tck, start);
        check(bn == 2 * n * h, {tag, " R7 busy length"}, bn, 2 * n * h);
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and slow default
        check(readback == 8'd0, "R1 readback", readback, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        burst(1, S, 1'b0, "R1 default slow");

        // R4 R2 R3: exhaustive line level combinations through readback
        for (int i = 0; i < 8; i++) begin
            send(3'd1, (i % 2 == 1) ? 32'h0000_0100 : 32'd0);
            send(3'd4, 32'((i >> 1) & 3));
            check(readback == 8'(i), "R4 R2 R3 readback", readback, i);
        end

        // R5: speed argument encoding
        send(3'd3, 32'h8000_0000);
        burst(1, F, line_tck, "R5 fast by high bit");
        send(3'd3, 32'd0);
        burst(1, S, line_tck, "R5 slow by zero");

        // R6 R7 R8: sweep count, speed and start level
        for (int sp = 0; sp < 2; sp++) begin
            for (int st = 0; st < 2; st++) begin
                for (int n = 0; n < 5; n++) begin
                    send(3'd3, 32'(sp));
                    send(3'd1, 32'(st));
                    burst(n, (sp == 1) ? F : S, st[0], (n == 0) ? "R8 zero" : "sweep");
                end
            end
        end

        // R9: commands during a burst are refused
        send(3'd3, 32'd0);
        send(3'd1, 32'd0);
        send(3'd4, 32'd0);
        begin
            int bn, fl;
            logic prev;
            bn = 0; fl = 0;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd2; cmd_arg = 32'd3;
            @(negedge clk);
            prev = line_tck;
            for (int m = 1; m < 200; m++) begin
                case (m)
                    1: begin cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 32'd1; end
                    2: begin cmd_valid = 1'b1; cmd_op = 3'd4; cmd_arg = 32'd3; end
                    3: begin cmd_valid = 1'b1; cmd_op = 3'd3; cmd_arg = 32'd1; end
                    4: begin cmd_valid = 1'b1; cmd_op = 3'd2; cmd_arg = 32'd7; end
                    default: begin cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 32'd0; end
                endcase
                if (line_tck !== prev) begin fl++; prev = line_tck; end
                if (!busy) break;
                bn++;
                @(negedge clk);
            end
            cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 32'd0;
            check(bn == 6 * S, "R9 burst not extended", bn, 6 * S);
            check(fl == 6, "R9 toggle count", fl, 6);
            check(line_tck == 1'b0, "R9 clock level", line_tck, 0);
            check(line_tms == 1'b0, "R9 mode line", line_tms, 0);
            check(line_tdi == 1'b0, "R9 data line", line_tdi, 0);
            @(negedge clk);
            check(busy == 1'b0, "R9 no restart", busy, 0);
        end
        burst(1, S, 1'b0, "R9 speed kept slow");

        // R10: unused opcodes change nothing
        send(3'd0, 32'hFFFF_FFFF);
        send(3'd5, 32'hFFFF_FFFF);
        send(3'd6, 32'hFFFF_FFFF);
        send(3'd7, 32'hFFFF_FFFF);
        check(readback == 8'd0, "R10 lines untouched", readback, 0);
        check(busy == 1'b0, "R10 no burst", busy, 0);
        burst(1, S, 1'b0, "R10 speed kept slow");

        // Collision: set-clock held across the final toggle of a burst
        send(3'd3, 32'd1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_arg = 32'd2;
        @(negedge clk);
        cmd_op = 3'd1; cmd_arg = 32'd1;
        for (int m = 0; m < 100 && busy; m++) @(negedge clk);
        check(line_tck == 1'b0, "R9 R6 burst ends first", line_tck, 0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 32'd0;
        check(line_tck == 1'b1, "R2 held command taken next", line_tck, 1);
        check(busy == 1'b0, "R7 idle after", busy, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule